// File: doc/BRIEF.md
# Frame Buffer Client Port for an Error-Correction Engine

This block is the port through which an error-correction engine reaches a frame buffer. Several requesters share the buffer, and a buffer manager arbitrates between them. The engine supplies a start offset, a direction and a transfer length. The port forms each byte address by joining a frame number with a running offset. The CPU loads the frame number into a register through a byte-wide interface. The port raises a request toward the buffer manager, and also raises a burst flag when more than one byte is wanted. It then waits for one acknowledge pulse for each byte that moves.

The buffer manager can give the memory to a higher-priority requester in the middle of a burst. While that happens the acknowledge stays low. The port holds its request, address and direction, so the burst resumes where it stopped and no byte is skipped or repeated.

The CPU writes the frame number as two bytes, low byte first. Only the high-byte write moves the value into the active frame register. If the high byte arrives while a transfer is running, the update waits until that transfer has finished. The CPU has to load a new frame number before each frame the engine works on.

Top module: `ecc_buf_port`

## Requirements
- R1: `mem_addr` is `{frame_num, offset}`. The frame number (FRAME_W = 11 bits) is in the upper bits and the offset (OFS_W = 12 bits) is in bits 11:0.
- R2: A start with `eng_burst` = 0 raises `mem_req` with `mem_burst` low and moves exactly one byte. A start with `eng_burst` = 1 raises both `mem_req` and `mem_burst`. `mem_burst` is never high without `mem_req`.
- R3: A burst moves `eng_len` bytes, and a length of 0 counts as one byte. A single access ignores `eng_len`. On the cycle after the last acknowledge, `mem_req` and `mem_burst` are low and `eng_done` is high for one clock.
- R4: The offset starts at `eng_offset` and rises by one after each acknowledge. It wraps modulo 2^OFS_W.
- R5: While `mem_ack` is low, `mem_req`, `mem_burst`, `mem_we` and `mem_addr` hold their values. A stall of N cycles lengthens the transfer by exactly N cycles.
- R6: A CPU write with `cpu_sel_hi` = 0 only stages the low byte and leaves `frame_num` unchanged. A write with `cpu_sel_hi` = 1 while idle loads `{cpu_wdata[FRAME_W-9:0], staged low byte}` into `frame_num` at that clock edge. The upper bits of the high byte are ignored.
- R7: A high-byte write during a transfer leaves `frame_num` and the frame bits of `mem_addr` unchanged until the transfer ends. The new value appears on the cycle after the `eng_done` pulse.
- R8: With the default registered read path (READ_REG = 1), each read acknowledge is followed one cycle later by `eng_rvalid` high for one clock. In that cycle `eng_rdata` holds the byte that `mem_rdata` carried during the acknowledge.
- R9: During a write transfer `mem_we` is high, and `mem_wdata` follows `eng_wdata`. `eng_byte_ack` is high in each acknowledge cycle of the port, so the engine knows when to present the next byte.
- R10: `eng_start` is ignored while `eng_busy` is high. The running transfer keeps its offset and length, and no second transfer follows it.
- R11: After reset, `mem_req`, `mem_burst`, `mem_we` and `eng_busy` are low and `frame_num` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr | input | 1 | CPU write strobe for the frame register |
| cpu_sel_hi | input | 1 | 0 selects the low byte, 1 selects the high byte (the high byte commits the value) |
| cpu_wdata | input | 8 | CPU write byte |
| frame_num | output | FRAME_W | Active frame number |
| eng_start | input | 1 | Engine start pulse (accepted only while idle) |
| eng_burst | input | 1 | 1 for a multi-byte burst, 0 for a single byte |
| eng_write | input | 1 | 1 for a write to the buffer, 0 for a read |
| eng_len | input | LEN_W | Burst length in bytes (0 counts as 1) |
| eng_offset | input | OFS_W | Start offset within the frame |
| eng_wdata | input | DATA_W | Write byte, held by the engine until its acknowledge |
| eng_busy | output | 1 | A transfer is in progress |
| eng_done | output | 1 | One-clock pulse after the final byte |
| eng_byte_ack | output | 1 | A byte was accepted in this cycle |
| eng_rdata | output | DATA_W | Read byte |
| eng_rvalid | output | 1 | `eng_rdata` is valid |
| mem_req | output | 1 | Request to the buffer manager |
| mem_burst | output | 1 | Multi-byte request flag |
| mem_we | output | 1 | Write direction |
| mem_addr | output | FRAME_W+OFS_W | Byte address |
| mem_wdata | output | DATA_W | Write byte toward the buffer |
| mem_ack | input | 1 | One-clock pulse for each byte completed |
| mem_rdata | input | DATA_W | Read byte from the buffer, valid while `mem_ack` is high |

## Verification
The bound checker watches several rules on every cycle:
- the burst flag is only ever high together with the request;
- the request, address and direction are frozen across every stalled cycle;
- the offset steps by exactly one after each acknowledge, including across the wrap;
- the frame part of the address never changes while a request is up;
- a done pulse follows a final acknowledge and coincides with the request being low;
- every read strobe follows a read acknowledge.

Other properties need the bench's scenarios:
- that the byte count matches the length, including the zero-length case and the single-access case that ignores it;
- that a stall costs exactly its own length in cycles;
- that read and write data reach the right addresses;
- that a low-byte-only write changes nothing;
- that a deferred high byte lands one cycle after done;
- that a start issued mid-transfer is dropped.

// File: rtl/ebp_pkg.sv
package ebp_pkg;
   typedef enum logic {
      XS_IDLE = 1'b0,
      XS_MOVE = 1'b1
   } xfer_state_e;
endpackage

// File: rtl/ebp_frame_reg.sv
module ebp_frame_reg #(
   parameter int FRAME_W = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_wr,
   input  logic               cpu_sel_hi,
   input  logic [7:0]         cpu_wdata,
   input  logic               busy,
   output logic [FRAME_W-1:0] frame_q
);
   localparam int HI_W = FRAME_W - 8;

   generate
      if (FRAME_W < 9 || FRAME_W > 16) begin : g_bad_width
         $error("ebp_frame_reg: FRAME_W must be in 9..16");
      end
   endgenerate

   logic [7:0]         lo_stage_q;
   logic [FRAME_W-1:0] held_q;
   logic               held_vld_q;
   logic [FRAME_W-1:0] new_val;

   assign new_val = {cpu_wdata[HI_W-1:0], lo_stage_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_stage_q <= '0;
         held_q     <= '0;
         held_vld_q <= 1'b0;
         frame_q    <= '0;
      end else begin
         if (cpu_wr && !cpu_sel_hi) begin
            lo_stage_q <= cpu_wdata;
         end
         if (cpu_wr && cpu_sel_hi) begin
            if (busy) begin
               held_q     <= new_val;
               held_vld_q <= 1'b1;
            end else begin
               frame_q    <= new_val;
               held_vld_q <= 1'b0;
            end
         end else if (held_vld_q && !busy) begin
            frame_q    <= held_q;
            held_vld_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ebp_xfer_fsm.sv
module ebp_xfer_fsm
   import ebp_pkg::*;
#(
   parameter int OFS_W = 12,
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eng_start,
   input  logic             eng_burst,
   input  logic             eng_write,
   input  logic [LEN_W-1:0] eng_len,
   input  logic [OFS_W-1:0] eng_offset,
   input  logic             mem_ack,
   output logic             busy,
   output logic             burst_o,
   output logic             we_o,
   output logic             done_o,
   output logic [OFS_W-1:0] ofs_q
);
   generate
      if (LEN_W < 1 || OFS_W < 1) begin : g_bad_width
         $error("ebp_xfer_fsm: LEN_W and OFS_W must be positive");
      end
   endgenerate

   xfer_state_e      state_q;
   logic [LEN_W-1:0] left_q;
   logic [LEN_W-1:0] first_len;
   logic             burst_q;
   logic             we_q;
   logic             last_byte;

   assign first_len = (!eng_burst || eng_len == '0) ? LEN_W'(1) : eng_len;
   assign last_byte = (left_q == LEN_W'(1));
   assign busy      = (state_q == XS_MOVE);
   assign burst_o   = busy & burst_q;
   assign we_o      = busy & we_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         left_q  <= '0;
         ofs_q   <= '0;
         burst_q <= 1'b0;
         we_q    <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            XS_IDLE: begin
               if (eng_start) begin
                  state_q <= XS_MOVE;
                  left_q  <= first_len;
                  ofs_q   <= eng_offset;
                  burst_q <= eng_burst;
                  we_q    <= eng_write;
               end
            end
            XS_MOVE: begin
               if (mem_ack) begin
                  ofs_q <= ofs_q + 1'b1;
                  if (last_byte) begin
                     state_q <= XS_IDLE;
                     burst_q <= 1'b0;
                     we_q    <= 1'b0;
                     done_o  <= 1'b1;
                  end else begin
                     left_q <= left_q - 1'b1;
                  end
               end
            end
            default: state_q <= XS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ebp_read_path.sv
module ebp_read_path #(
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_hit,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   generate
      if (READ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata  <= '0;
               rvalid <= 1'b0;
            end else begin
               rvalid <= rd_hit;
               if (rd_hit) rdata <= mem_rdata;
            end
         end
      end else begin : g_thru
         assign rdata  = mem_rdata;
         assign rvalid = rd_hit;
      end
   endgenerate
endmodule

// File: rtl/ecc_buf_port.sv
module ecc_buf_port #(
   parameter int FRAME_W  = 11,
   parameter int OFS_W    = 12,
   parameter int LEN_W    = 8,
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b1,
   localparam int ADDR_W  = FRAME_W + OFS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_wr,
   input  logic               cpu_sel_hi,
   input  logic [7:0]         cpu_wdata,
   output logic [FRAME_W-1:0] frame_num,
   input  logic               eng_start,
   input  logic               eng_burst,
   input  logic               eng_write,
   input  logic [LEN_W-1:0]   eng_len,
   input  logic [OFS_W-1:0]   eng_offset,
   input  logic [DATA_W-1:0]  eng_wdata,
   output logic               eng_busy,
   output logic               eng_done,
   output logic               eng_byte_ack,
   output logic [DATA_W-1:0]  eng_rdata,
   output logic               eng_rvalid,
   output logic               mem_req,
   output logic               mem_burst,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic               mem_ack,
   input  logic [DATA_W-1:0]  mem_rdata
);
   logic [OFS_W-1:0] ofs_q;
   logic             busy;
   logic             hit;

   ebp_frame_reg #(.FRAME_W(FRAME_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_wr    (cpu_wr),
      .cpu_sel_hi(cpu_sel_hi),
      .cpu_wdata (cpu_wdata),
      .busy      (busy),
      .frame_q   (frame_num)
   );

   ebp_xfer_fsm #(.OFS_W(OFS_W), .LEN_W(LEN_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .eng_start (eng_start),
      .eng_burst (eng_burst),
      .eng_write (eng_write),
      .eng_len   (eng_len),
      .eng_offset(eng_offset),
      .mem_ack   (hit),
      .busy      (busy),
      .burst_o   (mem_burst),
      .we_o      (mem_we),
      .done_o    (eng_done),
      .ofs_q     (ofs_q)
   );

   assign hit          = mem_ack & busy;
   assign mem_req      = busy;
   assign eng_busy     = busy;
   assign eng_byte_ack = hit;
   assign mem_addr     = {frame_num, ofs_q};
   assign mem_wdata    = eng_wdata;

   ebp_read_path #(.DATA_W(DATA_W), .READ_REG(READ_REG)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_hit   (hit & ~mem_we),
      .mem_rdata(mem_rdata),
      .rdata    (eng_rdata),
      .rvalid   (eng_rvalid)
   );
endmodule

// File: rtl/ebp_checker.sv
module ebp_checker #(
   parameter int FRAME_W  = 11,
   parameter int OFS_W    = 12,
   parameter int LEN_W    = 8,
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b1,
   localparam int ADDR_W  = FRAME_W + OFS_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic [FRAME_W-1:0] frame_num,
   input logic               eng_done,
   input logic               eng_rvalid,
   input logic               mem_req,
   input logic               mem_burst,
   input logic               mem_we,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic               mem_ack
);
   AST_BURST_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_burst |-> mem_req); // R2

   AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> (!mem_req ||
         mem_addr[OFS_W-1:0] == $past(mem_addr[OFS_W-1:0]) + 1'b1)); // R4

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
         $stable(mem_burst) && $stable(mem_we))); // R5

   AST_DONE_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |-> (!mem_req && !mem_burst)); // R3

   AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |-> $past(mem_req && mem_ack)); // R3

   AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> (!mem_req || $stable(frame_num))); // R7

   generate
      if (READ_REG) begin : g_rd
         AST_RVALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            eng_rvalid |-> $past(mem_req && mem_ack && !mem_we)); // R8
      end
   endgenerate
endmodule

bind ecc_buf_port ebp_checker #(
   .FRAME_W(FRAME_W), .OFS_W(OFS_W), .LEN_W(LEN_W),
   .DATA_W(DATA_W), .READ_REG(READ_REG)
) u_ebp_checker (.*);

// File: tb/ecc_buf_port_bench.sv
module ecc_buf_port_bench;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        burst;
      logic        we;
      logic [7:0]  len;
      logic [11:0] ofs;
      logic [7:0]  hp_at;
      logic [7:0]  hp_len;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 1'b0, 8'd0, 12'h005, 8'd0, 8'd0},
      '{1'b0, 1'b1, 8'd0, 12'h7FF, 8'd0, 8'd0},
      '{1'b1, 1'b0, 8'd4, 12'h010, 8'd0, 8'd0},
      '{1'b1, 1'b1, 8'd5, 12'h020, 8'd0, 8'd0},
      '{1'b1, 1'b0, 8'd6, 12'hFFD, 8'd2, 8'd3},
      '{1'b1, 1'b1, 8'd3, 12'h100, 8'd0, 8'd2},
      '{1'b1, 1'b0, 8'd0, 12'h040, 8'd0, 8'd0},
      '{1'b0, 1'b0, 8'd9, 12'h050, 8'd0, 8'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0, cpu_sel_hi = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [10:0] frame_num;
   logic        eng_start = 1'b0, eng_burst = 1'b0, eng_write = 1'b0;
   logic [7:0]  eng_len = '0;
   logic [11:0] eng_offset = '0;
   logic [7:0]  eng_wdata = '0;
   logic        eng_busy, eng_done, eng_byte_ack, eng_rvalid;
   logic [7:0]  eng_rdata;
   logic        mem_req, mem_burst, mem_we, mem_ack;
   logic [22:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        hp_busy = 1'b0;
   int          n_checks = 0, n_errors = 0;
   bit          finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] rpat(input logic [22:0] a);
      return a[7:0] ^ a[19:12];
   endfunction
   function automatic logic [7:0] wpat(input logic [22:0] a);
      return ~a[7:0] ^ 8'h35;
   endfunction

   // buffer manager model: a higher-priority requester wins whenever hp_busy is set
   assign mem_ack   = mem_req & ~hp_busy;
   assign mem_rdata = rpat(mem_addr);

   ecc_buf_port u_ecc_buf_port (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic write_frame(input logic [10:0] f);
      @(negedge clk); cpu_wr = 1'b1; cpu_sel_hi = 1'b0; cpu_wdata = f[7:0];
      @(negedge clk); cpu_sel_hi = 1'b1; cpu_wdata = {5'b10110, f[10:8]};
      @(negedge clk); cpu_wr = 1'b0; cpu_sel_hi = 1'b0;
   endtask

   task automatic run_vec(input int i);
      vec_t        v;
      int          bytes, idx, cend;
      logic        ev;
      logic [7:0]  ed;
      logic [10:0] frm;
      logic [22:0] ea;
      v   = VECS[i];
      frm = 11'(11'h123 + i * 11'h0B5);
      write_frame(frm);
      chk("R6 frame load", 32'(frame_num), 32'(frm));
      bytes = v.burst ? ((v.len == 0) ? 1 : int'(v.len)) : 1;
      eng_burst = v.burst; eng_write = v.we; eng_len = v.len;
      eng_offset = v.ofs; eng_start = 1'b1;
      @(negedge clk); eng_start = 1'b0;
      idx = 0; ev = 1'b0; ed = '0; cend = -1;
      for (int c = 0; c < 80; c++) begin
         hp_busy   = (c >= int'(v.hp_at)) && (c < int'(v.hp_at) + int'(v.hp_len));
         ea        = {frm, 12'(v.ofs + idx)};
         eng_wdata = wpat(ea);
         #1;
         chk("R8 rvalid", 32'(eng_rvalid), 32'(ev));
         if (ev) chk("R8 rdata", 32'(eng_rdata), 32'(ed));
         ev = 1'b0;
         if (!mem_req) begin cend = c; break; end
         chk("R1 R4 address", 32'(mem_addr), 32'(ea));
         chk("R2 burst flag", 32'(mem_burst), 32'(v.burst));
         chk("R9 direction", 32'(mem_we), 32'(v.we));
         if (mem_ack) begin
            chk("R9 byte ack", 32'(eng_byte_ack), 32'd1);
            if (v.we) chk("R9 write data", 32'(mem_wdata), 32'(wpat(ea)));
            else begin ev = 1'b1; ed = rpat(ea); end
            idx++;
         end
         @(negedge clk);
      end
      hp_busy = 1'b0;
      chk("R3 byte count", 32'(idx), 32'(bytes));
      chk("R5 cycles with stall", 32'(cend), 32'(bytes + int'(v.hp_len)));
      chk("R3 done pulse", 32'(eng_done), 32'd1);
      @(negedge clk);
      chk("R3 done one clock", 32'(eng_done), 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      int          acks;
      logic [10:0] fr;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 req", 32'(mem_req), 32'd0);
      chk("R11 burst", 32'(mem_burst), 32'd0);
      chk("R11 we", 32'(mem_we), 32'd0);
      chk("R11 busy", 32'(eng_busy), 32'd0);
      chk("R11 frame", 32'(frame_num), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 8; i++) run_vec(i);

      // R6 low byte alone has no effect
      fr = frame_num;
      @(negedge clk); cpu_wr = 1'b1; cpu_sel_hi = 1'b0; cpu_wdata = 8'hAA;
      @(negedge clk); cpu_wr = 1'b0;
      @(negedge clk);
      chk("R6 low byte only", 32'(frame_num), 32'(fr));

      // R7 high byte during a transfer is deferred
      write_frame(11'h2A5);
      eng_burst = 1'b1; eng_write = 1'b0; eng_len = 8'd3; eng_offset = 12'h000;
      hp_busy = 1'b1; eng_start = 1'b1;
      @(negedge clk); eng_start = 1'b0;
      cpu_wr = 1'b1; cpu_sel_hi = 1'b0; cpu_wdata = 8'h3C;
      @(negedge clk); cpu_sel_hi = 1'b1; cpu_wdata = 8'h06;
      @(negedge clk); cpu_wr = 1'b0; cpu_sel_hi = 1'b0;
      #1;
      chk("R7 frame held while busy", 32'(frame_num), 32'h2A5);
      chk("R7 address frame held", 32'(mem_addr[22:12]), 32'h2A5);
      hp_busy = 1'b0;
      for (int c = 0; c < 20 && mem_req; c++) begin
         chk("R7 address frame held", 32'(mem_addr[22:12]), 32'h2A5);
         @(negedge clk);
      end
      chk("R7 done seen", 32'(eng_done), 32'd1);
      chk("R7 frame still old at done", 32'(frame_num), 32'h2A5);
      @(negedge clk);
      chk("R7 deferred frame loaded", 32'(frame_num), 32'h63C);

      // R10 start while busy is ignored
      eng_burst = 1'b1; eng_write = 1'b0; eng_len = 8'd3; eng_offset = 12'h200;
      eng_start = 1'b1;
      @(negedge clk); eng_start = 1'b0;
      acks = 0;
      for (int c = 0; c < 20; c++) begin
         if (c == 1) begin
            eng_start = 1'b1; eng_offset = 12'h300; eng_len = 8'd9;
         end else eng_start = 1'b0;
         #1;
         if (!mem_req) break;
         chk("R10 offset unaffected", 32'(mem_addr[11:0]), 32'(12'h200 + acks));
         if (mem_ack) acks++;
         @(negedge clk);
      end
      eng_start = 1'b0;
      chk("R10 length unaffected", 32'(acks), 32'd3);
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         chk("R10 no second transfer", 32'(mem_req), 32'd0);
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule